// File: doc/BRIEF.md
# Single-Bank Row/Column Access Sequencer

This block controls one storage bank arranged as a grid of rows and columns, where each row is held in registers and behaves like a dynamic cell row. A requester presents a read or a write through a valid/ready handshake. The request names a row and a column within that row. The sequencer then walks through four timed phases: it opens the row's select line, senses the whole row into a holding register, then delivers or merges the selected column word, and finally precharges before it accepts anything else.

Sensing wipes the row. The sequencer therefore writes the held value back, with any write data merged in, at the end of the column phase, while the row is still selected. A built-in refresh scheduler raises a request at a fixed interval. Each refresh opens the next row in turn and restores it. A refresh that is waiting wins over a user request at the next idle point.

Every row keeps an age count since its last restore. A row that is not restored within the retention limit is marked corrupt from then on, and a sticky error output is raised. A read of a corrupt row returns zero.

Top module: `bank_seq_top`

## Requirements
- R1: While reset is held and directly after it is released, `req_ready` is 1, `wordline` is all zero, and `rd_valid` and `retention_err` are 0.
- R2: At most one bit of `wordline` is ever set. During the activate, sense and column phases, the set bit is the one at index `row`. During precharge and idle, no bit is set, and the selected bit does not change while it is set.
- R3: For an access accepted at clock edge k, `wordline` is nonzero for T_ACT+T_SENSE+T_COL cycles starting at edge k. It is then zero for T_PRE cycles of precharge before `req_ready` can return to 1. `req_ready` stays 0 from edge k until precharge ends.
- R4: A read drives `rd_valid` high for exactly one cycle, the last cycle of the column phase. In that cycle `rd_data` holds the word last stored at (`row`, `col`).
- R5: Sensing clears the stored row, and the row is written back before precharge. Repeated reads of the same word therefore return the same value.
- R6: A write replaces only the word at the selected column. The other columns of that row keep their values, and a write produces no `rd_valid` pulse.
- R7: Every REFRESH_INTERVAL cycles a refresh request is raised. Refreshes open rows 0, 1, 2 and so on in rotation, wrapping after the last row. `refresh_active` is high while a refresh sequence is in progress.
- R8: When a refresh request and a user request are both waiting at an idle point, the refresh starts first, and `req_ready` stays 0 throughout it.
- R9: A row that goes RETENTION cycles without a restore is marked corrupt. `retention_err` then rises and stays 1 until reset, and every later read of that row returns 0.
- R10: A refresh does not change the data held in a healthy row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_BITS | Row address field |
| req_col | input | COL_BITS | Column address field |
| req_wdata | input | WORD_W | Word to store on a write |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | WORD_W | Read word |
| wordline | output | 2^ROW_BITS | Row select lines, one-hot or zero |
| refresh_active | output | 1 | A refresh sequence is running |
| retention_err | output | 1 | Sticky flag: some row exceeded retention |

## Verification
Two functions can meet in the same idle cycle: the refresh scheduler's request and a user request already waiting on `req_valid`. The bench issues back-to-back reads so that a new request is always held high when the previous access finishes, and a refresh tick that falls inside an access therefore collides with it. In every such cycle the reference model expects the next state to be a refresh, with `req_ready` low. A second overlap, a row aging out in the same cycle that it is being sensed or restored, is judged by comparing the error flag and the read data against the model's per-row age counts on every clock.

// File: rtl/bank_seq_pkg.sv
`timescale 1ns/1ps
package bank_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ACT,
    PH_SENSE,
    PH_COL,
    PH_PRE
  } phase_e;
endpackage

// File: rtl/bank_phase_ctl.sv
`timescale 1ns/1ps
module bank_phase_ctl
  import bank_seq_pkg::*;
#(
  parameter int T_ACT   = 2,
  parameter int T_SENSE = 2,
  parameter int T_COL   = 1,
  parameter int T_PRE   = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e phase,
  output logic   phase_end
);
  localparam int TM1  = (T_ACT > T_SENSE) ? T_ACT : T_SENSE;
  localparam int TM2  = (T_COL > T_PRE) ? T_COL : T_PRE;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW   = (TMAX > 1) ? $clog2(TMAX) : 1;
  localparam logic [CW-1:0] L_ACT   = CW'(T_ACT - 1);
  localparam logic [CW-1:0] L_SENSE = CW'(T_SENSE - 1);
  localparam logic [CW-1:0] L_COL   = CW'(T_COL - 1);
  localparam logic [CW-1:0] L_PRE   = CW'(T_PRE - 1);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d, last_cnt;
  logic          step_en;

  always_comb begin
    case (phase_q)
      PH_ACT:   last_cnt = L_ACT;
      PH_SENSE: last_cnt = L_SENSE;
      PH_COL:   last_cnt = L_COL;
      default:  last_cnt = L_PRE;
    endcase
  end

  assign phase_end = (phase_q != PH_IDLE) && (cnt_q == last_cnt);
  assign step_en   = (phase_q != PH_IDLE) || start;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (phase_q == PH_IDLE) begin
      phase_d = PH_ACT;
      cnt_d   = '0;
    end else if (phase_end) begin
      cnt_d = '0;
      case (phase_q)
        PH_ACT:   phase_d = PH_SENSE;
        PH_SENSE: phase_d = PH_COL;
        PH_COL:   phase_d = PH_PRE;
        default:  phase_d = PH_IDLE;
      endcase
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (step_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/bank_refresh_sched.sv
`timescale 1ns/1ps
module bank_refresh_sched #(
  parameter int ROW_BITS         = 4,
  parameter int REFRESH_INTERVAL = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  output logic                pending,
  output logic [ROW_BITS-1:0] next_row
);
  localparam int TW = $clog2(REFRESH_INTERVAL);
  localparam logic [TW-1:0] T_LAST = TW'(REFRESH_INTERVAL - 1);

  logic [TW-1:0]       timer_q, timer_d;
  logic                pend_q, pend_d, tick;
  logic [ROW_BITS-1:0] ptr_q;

  assign tick    = (timer_q == T_LAST);
  assign timer_d = tick ? '0 : timer_q + 1'b1;
  assign pend_d  = (pend_q & ~take) | tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      timer_q <= timer_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_q <= '0;
    else if (take) ptr_q <= ptr_q + 1'b1;
  end

  assign pending  = pend_q;
  assign next_row = ptr_q;
endmodule

// File: rtl/bank_row_health.sv
`timescale 1ns/1ps
module bank_row_health #(
  parameter int ROW_BITS  = 4,
  parameter int RETENTION = 1024
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   restore_en,
  input  logic [ROW_BITS-1:0]    restore_row,
  output logic [2**ROW_BITS-1:0] corrupt,
  output logic                   err
);
  localparam int ROWS = 2**ROW_BITS;
  localparam int AW   = $clog2(RETENTION + 1);
  localparam logic [AW-1:0] LIMIT = AW'(RETENTION);

  logic [ROWS-1:0] expired;
  logic [ROWS-1:0] bad_q;
  logic            err_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [AW-1:0] age_q, age_d;
    logic          hit;
    assign hit        = restore_en && (restore_row == ROW_BITS'(r));
    assign expired[r] = (age_q == LIMIT);
    assign age_d      = hit ? '0 : (expired[r] ? age_q : age_q + 1'b1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age_q    <= '0;
        bad_q[r] <= 1'b0;
      end else begin
        age_q <= age_d;
        if (expired[r]) bad_q[r] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_q <= 1'b0;
    else if (|expired) err_q <= 1'b1;
  end

  assign corrupt = bad_q;
  assign err     = err_q;
endmodule

// File: rtl/bank_seq_top.sv
`timescale 1ns/1ps
module bank_seq_top
  import bank_seq_pkg::*;
#(
  parameter int ROW_BITS         = 4,
  parameter int COL_BITS         = 2,
  parameter int WORD_W           = 8,
  parameter int T_ACT            = 2,
  parameter int T_SENSE          = 2,
  parameter int T_COL            = 1,
  parameter int T_PRE            = 2,
  parameter int REFRESH_INTERVAL = 32,
  parameter int RETENTION        = 1024
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_BITS-1:0]    req_row,
  input  logic [COL_BITS-1:0]    req_col,
  input  logic [WORD_W-1:0]      req_wdata,
  output logic                   rd_valid,
  output logic [WORD_W-1:0]      rd_data,
  output logic [2**ROW_BITS-1:0] wordline,
  output logic                   refresh_active,
  output logic                   retention_err
);
  localparam int ROWS  = 2**ROW_BITS;
  localparam int COLS  = 2**COL_BITS;
  localparam int ROW_W = WORD_W * COLS;

  phase_e              phase;
  logic                phase_end, ref_pending, start_ref, accept, start;
  logic [ROW_BITS-1:0] ref_row;
  logic [ROWS-1:0]     corrupt;
  logic                sense_done, restore, wl_on;

  logic                op_ref_q, op_write_q;
  logic [ROW_BITS-1:0] row_q;
  logic [COL_BITS-1:0] col_q;
  logic [WORD_W-1:0]   wdata_q;
  logic [ROW_W-1:0]    sense_q, merged;
  logic [ROW_W-1:0]    mem_q [ROWS];

  assign start_ref = (phase == PH_IDLE) && ref_pending;
  assign req_ready = (phase == PH_IDLE) && !ref_pending;
  assign accept    = req_valid && req_ready;
  assign start     = start_ref || accept;

  bank_phase_ctl #(
    .T_ACT(T_ACT), .T_SENSE(T_SENSE), .T_COL(T_COL), .T_PRE(T_PRE)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .start(start),
    .phase(phase), .phase_end(phase_end)
  );

  bank_refresh_sched #(
    .ROW_BITS(ROW_BITS), .REFRESH_INTERVAL(REFRESH_INTERVAL)
  ) u_refresh (
    .clk(clk), .rst_n(rst_n), .take(start_ref),
    .pending(ref_pending), .next_row(ref_row)
  );

  bank_row_health #(
    .ROW_BITS(ROW_BITS), .RETENTION(RETENTION)
  ) u_health (
    .clk(clk), .rst_n(rst_n), .restore_en(restore), .restore_row(row_q),
    .corrupt(corrupt), .err(retention_err)
  );

  // Command latch, loaded when a sequence starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_ref_q   <= 1'b0;
      op_write_q <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      wdata_q    <= '0;
    end else if (start) begin
      op_ref_q   <= start_ref;
      op_write_q <= req_write && !start_ref;
      row_q      <= start_ref ? ref_row : req_row;
      col_q      <= req_col;
      wdata_q    <= req_wdata;
    end
  end

  assign sense_done = (phase == PH_SENSE) && phase_end;
  assign restore    = (phase == PH_COL) && phase_end;
  assign wl_on      = (phase == PH_ACT) || (phase == PH_SENSE) || (phase == PH_COL);

  always_comb begin
    merged = sense_q;
    if (op_write_q && !op_ref_q) merged[col_q*WORD_W +: WORD_W] = wdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sense_q <= '0;
    else if (sense_done) sense_q <= mem_q[row_q];
  end

  // Row storage: sensing clears the row, restore writes it back
  for (genvar r = 0; r < ROWS; r++) begin : g_mem
    logic sel;
    assign sel         = (row_q == ROW_BITS'(r));
    assign wordline[r] = wl_on && sel;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 mem_q[r] <= '0;
      else if (sense_done && sel) mem_q[r] <= '0;
      else if (restore && sel)    mem_q[r] <= merged;
    end
  end

  assign rd_valid       = restore && !op_write_q && !op_ref_q;
  assign rd_data        = corrupt[row_q] ? '0 : sense_q[col_q*WORD_W +: WORD_W];
  assign refresh_active = op_ref_q && (phase != PH_IDLE);
endmodule

// File: rtl/bank_seq_chk.sv
`timescale 1ns/1ps
module bank_seq_chk #(
  parameter int ROWS = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic [ROWS-1:0] wordline,
  input logic            rd_valid,
  input logic            retention_err,
  input logic            refresh_active
);
  p_single_wordline_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wordline));

  p_wordline_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wordline) && $past(|wordline)) |-> $stable(wordline));

  p_busy_not_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|wordline) |-> !req_ready);

  p_precharge_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|wordline) |=> !(|wordline));

  p_read_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_refresh_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_active |-> !req_ready);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retention_err |=> retention_err);
endmodule

bind bank_seq_top bank_seq_chk #(.ROWS(2**ROW_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .wordline(wordline),
  .rd_valid(rd_valid), .retention_err(retention_err),
  .refresh_active(refresh_active)
);

// File: tb/test_bank_seq_top.sv
`timescale 1ns/1ps
module test_bank_seq_top;
  localparam int RB = 3, CB = 2, WW = 4;
  localparam int TA = 1, TS = 2, TC = 1, TP = 1;
  localparam int RI = 24, RT = 150;
  localparam int NR = 2**RB, NC = 2**CB;
  localparam int S_END = TA + TS - 1;
  localparam int C_END = TA + TS + TC - 1;
  localparam int TOT   = TA + TS + TC + TP;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic          req_ready;
  logic [RB-1:0] req_row;
  logic [CB-1:0] req_col;
  logic [WW-1:0] req_wdata;
  logic          rd_valid;
  logic [WW-1:0] rd_data;
  logic [NR-1:0] wordline;
  logic          refresh_active, retention_err;

  always #10 clk = ~clk;

  bank_seq_top #(
    .ROW_BITS(RB), .COL_BITS(CB), .WORD_W(WW),
    .T_ACT(TA), .T_SENSE(TS), .T_COL(TC), .T_PRE(TP),
    .REFRESH_INTERVAL(RI), .RETENTION(RT)
  ) i_bank_seq_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .wordline(wordline), .refresh_active(refresh_active),
    .retention_err(retention_err)
  );

  // Behavioural reference model
  int m_mem [NR][NC];
  int m_sense [NC];
  int m_age [NR];
  bit m_bad [NR];
  bit m_err, m_busy, m_wr, m_ref, m_pend, m_live = 1'b0;
  int m_cnt, m_row, m_col, m_wd, m_timer, m_ptr;
  bit r8_due;
  bit tick, sref, acc, sns, rsto;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NR; r++) begin
        m_age[r] = 0; m_bad[r] = 1'b0;
        for (int c = 0; c < NC; c++) m_mem[r][c] = 0;
      end
      for (int c = 0; c < NC; c++) m_sense[c] = 0;
      m_err = 0; m_busy = 0; m_wr = 0; m_ref = 0; m_pend = 0;
      m_cnt = 0; m_row = 0; m_col = 0; m_wd = 0; m_timer = 0; m_ptr = 0;
      r8_due = 0; m_live = 1'b1;
    end else begin
      tick = (m_timer == RI - 1);
      sref = !m_busy && m_pend;
      acc  = !m_busy && !m_pend && req_valid;
      sns  = m_busy && m_cnt == S_END;
      rsto = m_busy && m_cnt == C_END;
      r8_due = sref && req_valid;
      for (int r = 0; r < NR; r++) begin
        if (m_age[r] == RT) begin m_bad[r] = 1'b1; m_err = 1'b1; end
        if (rsto && r == m_row) m_age[r] = 0;
        else if (m_age[r] != RT) m_age[r] = m_age[r] + 1;
      end
      if (sns) for (int c = 0; c < NC; c++) begin
        m_sense[c] = m_mem[m_row][c]; m_mem[m_row][c] = 0;
      end
      if (rsto) begin
        for (int c = 0; c < NC; c++) m_mem[m_row][c] = m_sense[c];
        if (m_wr && !m_ref) m_mem[m_row][m_col] = m_wd;
      end
      if (m_busy) begin
        if (m_cnt == TOT - 1) m_busy = 1'b0; else m_cnt = m_cnt + 1;
      end else if (sref) begin
        m_busy = 1; m_cnt = 0; m_ref = 1; m_wr = 0; m_row = m_ptr;
        m_ptr = (m_ptr + 1) % NR;
      end else if (acc) begin
        m_busy = 1; m_cnt = 0; m_ref = 0; m_wr = req_write;
        m_row = int'(req_row); m_col = int'(req_col); m_wd = int'(req_wdata);
      end
      m_pend  = (m_pend && !sref) || tick;
      m_timer = tick ? 0 : m_timer + 1;
    end
  end

  // Per-clock comparison against the model
  int checks = 0, errors = 0, r8_hits = 0;
  int e_wl, e_rdd;
  bit e_rdv;

  task automatic cmp(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && m_live) begin
      e_wl  = (m_busy && m_cnt <= C_END) ? (1 << m_row) : 0;
      e_rdv = m_busy && m_cnt == C_END && !m_wr && !m_ref;
      e_rdd = m_bad[m_row] ? 0 : m_sense[m_col];
      cmp(req_ready == (!m_busy && !m_pend), "R3 req_ready", int'(req_ready), int'(!m_busy && !m_pend));
      cmp(int'(wordline) == e_wl, "R2 wordline", int'(wordline), e_wl);
      cmp(rd_valid == e_rdv, "R4 rd_valid", int'(rd_valid), int'(e_rdv));
      if (e_rdv) cmp(int'(rd_data) == e_rdd, "R4 rd_data", int'(rd_data), e_rdd);
      cmp(refresh_active == (m_busy && m_ref), "R7 refresh_active", int'(refresh_active), int'(m_busy && m_ref));
      cmp(retention_err == m_err, "R9 retention_err", int'(retention_err), int'(m_err));
      if (r8_due) begin
        r8_hits++;
        cmp(refresh_active && !req_ready, "R8 refresh first", int'(refresh_active), 1);
      end
    end
  end

  // Directed checks
  int dchecks = 0, derrors = 0;

  task automatic dchk(input bit ok, input string tag, input int act, input int exp);
    dchecks++;
    if (!ok) begin
      derrors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic access(input bit wr, input int row, input int col, input int wd,
                        input bit timed, output int rdat);
    int n;
    rdat = -1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_row = RB'(row); req_col = CB'(col); req_wdata = WW'(wd);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (timed) begin
      n = 0;
      while (|wordline && n < 50) begin n++; @(negedge clk); end
      dchk(n == TA + TS + TC, "R3 wordline length", n, TA + TS + TC);
      n = 0;
      while (!req_ready && n < 50) begin n++; @(negedge clk); end
      dchk(n == TP, "R3 precharge length", n, TP);
    end
    if (!wr) begin
      n = 0;
      while (!rd_valid && n < 50) begin n++; @(negedge clk); end
      rdat = int'(rd_data);
    end
  endtask

  int d, w0, lim;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_row = '0; req_col = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    dchk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    dchk(wordline == '0, "R1 wordline in reset", int'(wordline), 0);
    dchk(rd_valid == 1'b0, "R1 rd_valid in reset", int'(rd_valid), 0);
    dchk(retention_err == 1'b0, "R1 err in reset", int'(retention_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    dchk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

    access(1, 2, 1, 'hA, 1, d);
    access(1, 2, 3, 'h5, 0, d);
    access(0, 2, 1, 0, 0, d);  dchk(d == 'hA, "R4 read word", d, 'hA);
    access(0, 2, 3, 0, 0, d);  dchk(d == 'h5, "R6 second column", d, 'h5);
    access(0, 2, 0, 0, 0, d);  dchk(d == 0, "R6 untouched column", d, 0);
    access(0, 2, 1, 0, 0, d);  dchk(d == 'hA, "R5 reread after restore", d, 'hA);
    access(1, 5, 0, 'h3, 0, d);
    access(0, 5, 0, 0, 0, d);  dchk(d == 'h3, "R4 other row", d, 'h3);

    // Back-to-back reads so refresh ticks collide with waiting requests
    for (int i = 0; i < 12; i++) begin
      access(0, 2, (i % 2 == 0) ? 1 : 3, 0, 0, d);
      dchk(d == ((i % 2 == 0) ? 'hA : 'h5), "R10 data across refresh", d, (i % 2 == 0) ? 'hA : 'h5);
    end
    dchk(r8_hits > 0, "R8 collision seen", r8_hits, 1);

    // Round-robin order of refresh rows
    lim = 0;
    while (!refresh_active && lim < 200) begin lim++; @(negedge clk); end
    w0 = int'(wordline);
    while (refresh_active && lim < 400) begin lim++; @(negedge clk); end
    while (!refresh_active && lim < 600) begin lim++; @(negedge clk); end
    dchk(int'(wordline) == ((w0 == (1 << (NR - 1))) ? 1 : (w0 << 1)), "R7 next refresh row",
         int'(wordline), (w0 == (1 << (NR - 1))) ? 1 : (w0 << 1));

    // Leave row 5 alone until it ages out
    lim = 0;
    while (!m_bad[5] && lim < 1000) begin lim++; @(negedge clk); end
    dchk(m_bad[5], "R9 row aged out", int'(m_bad[5]), 1);
    dchk(retention_err == 1'b1, "R9 sticky flag", int'(retention_err), 1);
    access(0, 5, 0, 0, 0, d);  dchk(d == 0, "R9 corrupt row reads zero", d, 0);
    access(0, 5, 0, 0, 0, d);  dchk(d == 0, "R9 still zero", d, 0);
    dchk(retention_err == 1'b1, "R9 flag held", int'(retention_err), 1);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks + dchecks, errors + derrors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks + dchecks + 1, errors + derrors + 1);
    $finish;
  end
endmodule